// File: doc/BRIEF.md
# Audio Link Output Framer

This block assembles and shifts out the frame that a controller sends to an audio codec over a time-division serial link. Each frame has 256 bit clocks: a 16-bit tag slot, which says which of the later slots hold data, followed by twelve 20-bit data slots. The first two data slots carry a register command to the codec: a read/write flag with a register index, then the write data. The next two carry the left and right playback samples. The remaining eight slots are reserved and are sent as zeros.

At each frame boundary the block samples a frame strobe. If the strobe is high, it latches the pending command and both samples into a frame buffer and starts a new frame. While a frame is in flight, changes at the inputs have no effect on it. The tag's per-slot flags are derived from what was latched. A slot whose flag is clear goes out as zeros. The register index always has its lowest bit cleared. The serial line changes on the rising bit-clock edge, MSB first. A frame sync marks the tag slot.

Top module: `aclink_out_framer`

## Requirements
- R1: While `rst_n` is low at a rising edge, and after it until the first frame starts, `sdo`, `fsync` and `cmd_taken` are 0.
- R2: `frame_go` high at an edge where the block is idle or sending the last bit of a frame starts a frame. `fsync` is 1 for the 16 clocks after that edge. The tag MSB appears one clock after `fsync` rises. The 256 frame bits follow back to back, MSB first, and a new frame may start with no gap.
- R3: Tag bit 15 is 1 exactly when at least one of tag bits 14..3 is 1.
- R4: Tag bits 14 down to 3 are the valid flags of slots 1 to 12 in that order. Tag bits 2..0 are 0.
- R5: Slot 1, when a command was latched, has the flag at bit 19 (1 = read, 0 = write), the register index at bits 18..12 with bit 12 forced to 0, and zeros at bits 11..0. Its tag flag is set. With no command latched, the slot and its flag are 0.
- R6: Slot 2 carries the write data at bits 19..4, with bits 3..0 at 0, and its flag is set only for a latched write. For a read, or with no command, the slot and its flag are 0.
- R7: Slots 3 and 4 carry the left and right samples at bits 19..4, with bits 3..0 at 0. A sample narrower than 16 bits (`SAMPLE_W`) sits at the top with zero low bits. A sample whose valid input was 0 when latched goes out as zeros, with its flag at 0.
- R8: Slots 5 to 12 are all zeros, and their tag flags are 0.
- R9: Frame contents are fixed at the starting edge; later input changes do not alter that frame. `cmd_taken` pulses for one clock, together with the rise of `fsync`, only when `cmd_pending` was high at that edge.
- R10: If `frame_go` is low at the last-bit edge, the line stays 0 and `fsync` stays low until a new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | Frame strobe, sampled at frame boundaries |
| cmd_pending | input | 1 | A register command is waiting |
| cmd_read | input | 1 | 1 = read command, 0 = write command |
| cmd_index | input | 7 | Register index |
| cmd_wdata | input | 16 | Write data |
| cmd_taken | output | 1 | One-clock pulse: command latched into the frame |
| left_valid | input | 1 | Left sample present |
| left_sample | input | SAMPLE_W | Left playback sample |
| right_valid | input | 1 | Right sample present |
| right_sample | input | SAMPLE_W | Right playback sample |
| sdo | output | 1 | Serial data out |
| fsync | output | 1 | Frame sync |

## Verification
Two things happen on the same edge: the last bit of one frame is shifted out, and the next frame's contents are latched, with `fsync` rising and `cmd_taken` pulsing. The bench holds `frame_go` high so that frames run back to back, and changes every input just after each latch. A wrong buffer update would therefore corrupt either the final bit of the old frame or the whole of the new one. A behavioural model rebuilds each frame as a 256-bit word from the latched values and compares `sdo`, `fsync` and `cmd_taken` on every clock. A reset in the middle of a frame and an idle stop are also checked.

// File: rtl/aclink_out_pkg.sv
package aclink_out_pkg;
    localparam int TAG_W      = 16;
    localparam int SLOT_W     = 20;
    localparam int NUM_SLOTS  = 12;
    localparam int IDX_W      = 7;
    localparam int DATA_W     = 16;
    localparam int PAD_W      = SLOT_W - DATA_W;
    localparam int TAG_PAD_W  = TAG_W - 1 - NUM_SLOTS;
    localparam int SLOT_SEL_W = $clog2(NUM_SLOTS + 1);
    localparam int BIT_SEL_W  = $clog2(SLOT_W);
    localparam int CMD_SLOT   = 1;
    localparam int DATA_SLOT  = 2;
    localparam int LEFT_SLOT  = 3;
    localparam int RIGHT_SLOT = 4;
    localparam int IDX_LSB    = SLOT_W - 1 - IDX_W;

    typedef struct packed {
        logic              cmd_v;
        logic              rd;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
        logic              left_v;
        logic [DATA_W-1:0] left;
        logic              right_v;
        logic [DATA_W-1:0] right;
    } frame_buf_t;
endpackage

// File: rtl/aclink_bit_timer.sv
module aclink_bit_timer
    import aclink_out_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_go,
    output logic                  run,
    output logic [SLOT_SEL_W-1:0] slot,
    output logic [BIT_SEL_W-1:0]  bitp,
    output logic                  fsync,
    output logic                  boundary
);
    localparam logic [SLOT_SEL_W-1:0] LAST_SLOT = SLOT_SEL_W'(NUM_SLOTS);
    localparam logic [BIT_SEL_W-1:0]  TOP_BIT   = BIT_SEL_W'(SLOT_W - 1);
    localparam logic [BIT_SEL_W-1:0]  TAG_END   = BIT_SEL_W'(PAD_W);

    typedef struct packed {
        logic                  run;
        logic [SLOT_SEL_W-1:0] slot;
        logic [BIT_SEL_W-1:0]  bitp;
        logic                  fsync;
    } tim_t;

    tim_t tim_d, tim_q;
    logic last_bit, slot_end;

    always_comb begin
        last_bit = (tim_q.slot == LAST_SLOT) && (tim_q.bitp == '0);
        slot_end = (tim_q.slot == '0) ? (tim_q.bitp == TAG_END) : (tim_q.bitp == '0);
        boundary = !tim_q.run || last_bit;
        tim_d    = tim_q;
        if (boundary) begin
            tim_d.run   = frame_go;
            tim_d.slot  = '0;
            tim_d.bitp  = TOP_BIT;
            tim_d.fsync = frame_go;
        end else begin
            tim_d.fsync = (tim_q.slot == '0) && (tim_q.bitp != TAG_END);
            if (slot_end) begin
                tim_d.slot = tim_q.slot + 1'b1;
                tim_d.bitp = TOP_BIT;
            end else begin
                tim_d.bitp = tim_q.bitp - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tim_q <= '0;
        else        tim_q <= tim_d;
    end

    assign run   = tim_q.run;
    assign slot  = tim_q.slot;
    assign bitp  = tim_q.bitp;
    assign fsync = tim_q.fsync;

    // R2: sync drops exactly as slot 1 begins
    p_sync_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tim_q.fsync) |-> (tim_q.slot == SLOT_SEL_W'(1) && tim_q.bitp == TOP_BIT));
    // R10: no strobe at the last bit ends the run
    p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tim_q.run && last_bit && !frame_go) |=> !tim_q.run);
endmodule

// File: rtl/aclink_frame_buffer.sv
module aclink_frame_buffer
    import aclink_out_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              cmd_pending,
    input  logic              cmd_read,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              left_v,
    input  logic [DATA_W-1:0] left,
    input  logic              right_v,
    input  logic [DATA_W-1:0] right,
    output frame_buf_t        fb,
    output logic              cmd_taken
);
    typedef struct packed {
        frame_buf_t fb;
        logic       taken;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d       = buf_q;
        buf_d.taken = 1'b0;
        if (take) begin
            buf_d.fb.cmd_v   = cmd_pending;
            buf_d.fb.rd      = cmd_read;
            buf_d.fb.idx     = cmd_index;
            buf_d.fb.wdata   = cmd_wdata;
            buf_d.fb.left_v  = left_v;
            buf_d.fb.left    = left;
            buf_d.fb.right_v = right_v;
            buf_d.fb.right   = right;
            buf_d.taken      = cmd_pending;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign fb        = buf_q.fb;
    assign cmd_taken = buf_q.taken;

    // R9: frame contents frozen between boundaries
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(buf_q.fb));
    // R9: a consume pulse always has a latched command behind it
    p_taken_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_q.taken |-> buf_q.fb.cmd_v);
endmodule

// File: rtl/aclink_slot_builder.sv
module aclink_slot_builder
    import aclink_out_pkg::*;
(
    input  frame_buf_t                      fb,
    output logic [NUM_SLOTS:0][SLOT_W-1:0]  words
);
    logic [NUM_SLOTS:1] slot_vld;
    logic [TAG_W-1:0]   tag;

    always_comb begin
        slot_vld             = '0;
        slot_vld[CMD_SLOT]   = fb.cmd_v;
        slot_vld[DATA_SLOT]  = fb.cmd_v && !fb.rd;
        slot_vld[LEFT_SLOT]  = fb.left_v;
        slot_vld[RIGHT_SLOT] = fb.right_v;

        words = '0;
        if (slot_vld[CMD_SLOT])
            words[CMD_SLOT] = {fb.rd, fb.idx[IDX_W-1:1], 1'b0, {IDX_LSB{1'b0}}};
        if (slot_vld[DATA_SLOT])
            words[DATA_SLOT] = {fb.wdata, {PAD_W{1'b0}}};
        if (slot_vld[LEFT_SLOT])
            words[LEFT_SLOT] = {fb.left, {PAD_W{1'b0}}};
        if (slot_vld[RIGHT_SLOT])
            words[RIGHT_SLOT] = {fb.right, {PAD_W{1'b0}}};

        tag            = '0;
        tag[TAG_W-1]   = |slot_vld;
        for (int s = 1; s <= NUM_SLOTS; s++)
            tag[TAG_W-1-s] = slot_vld[s];
        words[0] = {tag, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/aclink_out_framer.sv
module aclink_out_framer
    import aclink_out_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_go,
    input  logic                cmd_pending,
    input  logic                cmd_read,
    input  logic [IDX_W-1:0]    cmd_index,
    input  logic [DATA_W-1:0]   cmd_wdata,
    output logic                cmd_taken,
    input  logic                left_valid,
    input  logic [SAMPLE_W-1:0] left_sample,
    input  logic                right_valid,
    input  logic [SAMPLE_W-1:0] right_sample,
    output logic                sdo,
    output logic                fsync
);
    localparam int ALIGN_SH = DATA_W - SAMPLE_W;

    logic                          run, boundary, take;
    logic [SLOT_SEL_W-1:0]         slot;
    logic [BIT_SEL_W-1:0]          bitp;
    logic [DATA_W-1:0]             left_al, right_al;
    frame_buf_t                    fb;
    logic [NUM_SLOTS:0][SLOT_W-1:0] words;

    typedef struct packed {
        logic sdo;
    } out_t;
    out_t out_d, out_q;

    assign left_al  = DATA_W'(left_sample)  << ALIGN_SH;
    assign right_al = DATA_W'(right_sample) << ALIGN_SH;
    assign take     = boundary && frame_go;

    aclink_bit_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_go (frame_go),
        .run      (run),
        .slot     (slot),
        .bitp     (bitp),
        .fsync    (fsync),
        .boundary (boundary)
    );

    aclink_frame_buffer u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .cmd_pending (cmd_pending),
        .cmd_read    (cmd_read),
        .cmd_index   (cmd_index),
        .cmd_wdata   (cmd_wdata),
        .left_v      (left_valid),
        .left        (left_al),
        .right_v     (right_valid),
        .right       (right_al),
        .fb          (fb),
        .cmd_taken   (cmd_taken)
    );

    aclink_slot_builder u_build (
        .fb    (fb),
        .words (words)
    );

    always_comb begin
        out_d     = out_q;
        out_d.sdo = run ? words[slot][bitp] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign sdo = out_q.sdo;

    // R5: lowest index bit never leaves as 1
    p_even_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slot == SLOT_SEL_W'(CMD_SLOT) && bitp == BIT_SEL_W'(IDX_LSB)) |=> !sdo);
    // R8: reserved slots are silent
    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slot > SLOT_SEL_W'(RIGHT_SLOT)) |=> !sdo);
    // R4: low tag pad bits are zero
    p_tag_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slot == '0 && bitp < BIT_SEL_W'(PAD_W + TAG_PAD_W)) |=> !sdo);
    // R9: consume pulse coincides with the sync rise
    p_taken_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_taken |-> $rose(fsync));
    // R10: idle line stays low
    p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sdo);
endmodule

// File: tb/aclink_out_framer_test.sv
module aclink_out_framer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n, frame_go, cmd_pending, cmd_read, left_valid, right_valid;
    logic [6:0]  cmd_index;
    logic [15:0] cmd_wdata, left_sample, right_sample;
    logic cmd_taken, sdo, fsync;

    aclink_out_framer uut (
        .clk(clk), .rst_n(rst_n), .frame_go(frame_go),
        .cmd_pending(cmd_pending), .cmd_read(cmd_read), .cmd_index(cmd_index),
        .cmd_wdata(cmd_wdata), .cmd_taken(cmd_taken),
        .left_valid(left_valid), .left_sample(left_sample),
        .right_valid(right_valid), .right_sample(right_sample),
        .sdo(sdo), .fsync(fsync)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit chk_en = 1'b0, done = 1'b0;

    // behavioural reference
    int m_pos = -1, e_bit = -1, m_frames = 0;
    logic [255:0] m_fr = '0;
    logic e_sdo = 1'b0, e_fs = 1'b0, e_tk = 1'b0;

    function automatic logic [255:0] build(input logic pend, input logic rd,
            input logic [6:0] idx, input logic [15:0] wd, input logic lv,
            input logic [15:0] l, input logic rv, input logic [15:0] r);
        logic [19:0] w1, w2, w3, w4;
        logic [15:0] tag;
        logic s2v;
        s2v = pend && !rd;
        w1  = pend ? {rd, idx & 7'h7E, 12'h000} : 20'h0;
        w2  = s2v  ? {wd, 4'h0} : 20'h0;
        w3  = lv   ? {l, 4'h0}  : 20'h0;
        w4  = rv   ? {r, 4'h0}  : 20'h0;
        tag = {(pend | lv | rv), pend, s2v, lv, rv, 11'h0};
        return {tag, w1, w2, w3, w4, 160'h0};
    endfunction

    function automatic string req_of(input int b);
        if (b < 0)   return "R10";
        if (b == 0)  return "R3";
        if (b < 16)  return "R4";
        if (b < 36)  return "R5";
        if (b < 56)  return "R6";
        if (b < 96)  return "R7";
        return "R8";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = -1; e_bit = -1; e_sdo = 0; e_fs = 0; e_tk = 0;
        end else begin
            if (m_pos >= 0) begin e_sdo = m_fr[255 - m_pos]; e_bit = m_pos; end
            else begin e_sdo = 1'b0; e_bit = -1; end
            if (m_pos < 0 || m_pos == 255) begin
                if (frame_go) begin
                    m_fr = build(cmd_pending, cmd_read, cmd_index, cmd_wdata,
                                 left_valid, left_sample, right_valid, right_sample);
                    m_pos = 0; e_fs = 1'b1; e_tk = cmd_pending; m_frames++;
                end else begin
                    m_pos = -1; e_fs = 1'b0; e_tk = 1'b0;
                end
            end else begin
                m_pos++;
                e_fs = (m_pos < 16);
                e_tk = 1'b0;
            end
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !done) begin
            if (!rst_n) begin
                check("R1", "sdo in reset", sdo, 1'b0);
                check("R1", "fsync in reset", fsync, 1'b0);
                check("R1", "cmd_taken in reset", cmd_taken, 1'b0);
            end else begin
                check("R2", "fsync", fsync, e_fs);
                check("R9", "cmd_taken", cmd_taken, e_tk);
                check(req_of(e_bit), $sformatf("sdo bit %0d", e_bit), sdo, e_sdo);
            end
        end
    end

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        report();
    end

    // load values, wait until latched, then disturb inputs (R9)
    task automatic load(input logic pend, input logic rd, input logic [6:0] idx,
            input logic [15:0] wd, input logic lv, input logic [15:0] l,
            input logic rv, input logic [15:0] r);
        int f;
        @(negedge clk);
        cmd_pending = pend; cmd_read = rd; cmd_index = idx; cmd_wdata = wd;
        left_valid = lv; left_sample = l; right_valid = rv; right_sample = r;
        f = m_frames;
        while (m_frames == f) @(negedge clk);
        cmd_pending = 1'b0; cmd_read = ~rd; cmd_index = ~idx; cmd_wdata = ~wd;
        left_valid = ~lv; left_sample = ~l; right_valid = ~rv; right_sample = ~r;
    endtask

    initial begin
        rst_n = 0; frame_go = 0; cmd_pending = 0; cmd_read = 0; cmd_index = '0;
        cmd_wdata = '0; left_valid = 0; left_sample = '0; right_valid = 0; right_sample = '0;
        @(posedge clk);
        chk_en = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (20) @(negedge clk);                 // R1 idle after reset
        frame_go = 1;
        load(1, 0, 7'h2B, 16'hA5C3, 1, 16'h8001, 1, 16'h7FFE); // R5 odd index write
        load(1, 1, 7'h11, 16'hFFFF, 1, 16'h1234, 0, 16'hBEEF); // R6 read hides data
        load(0, 0, 7'h00, 16'h0000, 0, 16'hFFFF, 0, 16'hFFFF); // R3 empty frame
        load(0, 0, 7'h55, 16'h1111, 0, 16'h0F0F, 1, 16'hC0DE); // R7 right only
        load(1, 0, 7'h7F, 16'h0001, 0, 16'h0000, 0, 16'h0000); // R5 top index
        frame_go = 0;                                           // R10 stop
        repeat (320) @(negedge clk);
        frame_go = 1;
        load(1, 0, 7'h04, 16'hCAFE, 1, 16'h4321, 1, 16'h8765);
        frame_go = 0;
        repeat (100) @(negedge clk);
        rst_n = 0;                                              // R1 reset mid frame
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (20) @(negedge clk);
        frame_go = 1;
        load(1, 1, 7'h3A, 16'h0000, 1, 16'hFFFF, 1, 16'h0001);
        frame_go = 0;
        repeat (300) @(negedge clk);
        report();
    end
endmodule